// File: doc/BRIEF.md
# Push-Button Press Pulse Generator

This block takes the raw level from a mechanical push-button, which bounces for some time after each press and release, and turns it into exactly one pulse, one clock cycle wide, for each real press. A downstream counter can use that pulse as an ordinary enable. The button is never used as a clock. It passes through a two-flop synchronizer into the system clock domain, and every register in the block runs on the single system clock.

In the default recognition mode, the synchronized samples are shifted into a 16-entry history. A press is accepted only when that history shows a stable rise: two low samples followed by fourteen high samples. A bouncing input never forms this picture, so it produces no extra pulses.

A build parameter selects a lockout mode instead. In that mode the block fires on the first low-to-high change of the synchronized level and then ignores the input for a fixed number of cycles. This mode answers much sooner, but it also accepts a one-cycle glitch as a press.

Top module: `press_pulse_top`

## Requirements
- R1: A synchronous reset clears every register. `pressPulse` is low while reset is high and in the cycle after it is released, whatever `btnRaw` does.
- R2: `btnRaw` only enters two reset-to-0 flops clocked by `clk` in series. No level change on it can affect `pressPulse` before the third rising edge, counting the first edge that samples the new level as edge 1.
- R3: Recognition mode: when `btnRaw` has been sampled low for at least two edges and then high for at least fourteen, `pressPulse` rises right after edge 17, counting the first high-sampling edge as edge 1.
- R4: Every pulse lasts exactly one clock cycle.
- R5: Recognition mode, encoding: the history holds the synchronized samples with the newest at bit 0. A pulse is produced only when the history equals 16'b0011111111111111. A high run of 14 samples after two lows fires, a run of 13 does not, and bounce bursts whose high runs are shorter than 14 give no pulse.
- R6: A press held for hundreds of cycles gives exactly one pulse, and its release, bouncing or clean in recognition mode and clean in lockout mode, gives none.
- R7: Lockout mode: the first low-to-high change fires `pressPulse` right after edge 3, counting the first high-sampling edge as edge 1.
- R8: Lockout mode: during the HOLD_CYCLES edges that follow a pulse, the input is ignored. A single-cycle high glitch on an idle input is accepted as a press.
- R9: Lockout mode: after the hold-off, a level still high gives no pulse, while a new low-to-high change fires again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register uses its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| btnRaw | input | 1 | Raw, asynchronous, bouncing button level |
| pressPulse | output | 1 | One-cycle pulse per recognised press |

## Verification
The bench targets the 14-versus-13 high-run boundary. An off-by-one in the pattern width or in the bit order would fire on the short run or miss the long one. It also checks exact pulse latency in both modes. A missing or extra synchronizer stage moves the pulse by a cycle and is reported.

Single-cycle glitches and second presses that land inside and outside the hold-off window expose a lockout counter with the wrong length, or one that keeps sampling while it is blocked. Randomized bounce bursts before and after a stable level catch designs that pulse more than once per press or pulse on release.

// File: rtl/press_pulse_pkg.sv
package press_pulse_pkg;

  // Strobes issued by the control block to the datapath each cycle.
  typedef struct packed {
    logic fire;      // register a press pulse at this edge
    logic sampleEn;  // allow the edge-reference sample to follow the input
  } ppStrobe_t;

  // Build the stable-rise pattern: lowLen zeros above highLen ones.
  function automatic logic [63:0] risePattern(input int histLen, input int lowLen);
    logic [63:0] pat;
    pat = '0;
    for (int i = 0; i < histLen - lowLen; i++) pat[i] = 1'b1;
    return pat;
  endfunction

endpackage

// File: rtl/press_pulse_dp.sv
module press_pulse_dp
  import press_pulse_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HIST_LEN    = 16,
  parameter int LOW_LEN     = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                btnRaw,
  input  ppStrobe_t           strobes,
  output logic [HIST_LEN-1:0] histQ,
  output logic                histMatch,
  output logic                riseSeen,
  output logic                pulseOut
);

  localparam logic [63:0] PAT_WIDE = risePattern(HIST_LEN, LOW_LEN);
  localparam logic [HIST_LEN-1:0] PATTERN = PAT_WIDE[HIST_LEN-1:0];

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncLevel;
  logic                   prevSample;
  logic                   pulseQ;

  // Synchronizer chain: stage 0 takes the raw pin, each further stage its predecessor.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (rst) begin
        syncQ[s] <= 1'b0;
      end else if (s == 0) begin
        syncQ[s] <= btnRaw;
      end else begin
        syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  end

  assign syncLevel = syncQ[SYNC_STAGES-1];

  // Sample history, newest sample at bit 0.
  always_ff @(posedge clk) begin
    if (rst) histQ <= '0;
    else     histQ <= {histQ[HIST_LEN-2:0], syncLevel};
  end

  // Edge reference for lockout mode; frozen while sampling is disabled.
  always_ff @(posedge clk) begin
    if (rst)                   prevSample <= 1'b0;
    else if (strobes.sampleEn) prevSample <= syncLevel;
  end

  always_ff @(posedge clk) begin
    if (rst) pulseQ <= 1'b0;
    else     pulseQ <= strobes.fire;
  end

  assign histMatch = (histQ == PATTERN);
  assign riseSeen  = syncLevel & ~prevSample;
  assign pulseOut  = pulseQ;

endmodule

// File: rtl/press_pulse_ctrl.sv
module press_pulse_ctrl
  import press_pulse_pkg::*;
#(
  parameter bit LOCKOUT_MODE = 1'b0,
  parameter int HOLD_CYCLES  = 16,
  localparam int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             histMatch,
  input  logic             riseSeen,
  output ppStrobe_t        strobes,
  output logic [CNT_W-1:0] holdCnt
);

  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES);

  logic holdIdle;
  logic fireNow;

  assign holdIdle = (holdCnt == '0);
  assign fireNow  = LOCKOUT_MODE ? (riseSeen && holdIdle) : histMatch;

  // Hold-off counter: loaded on a lockout pulse, then drains one per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
    end else if (LOCKOUT_MODE && fireNow) begin
      holdCnt <= HOLD_LOAD;
    end else if (!holdIdle) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.fire     = fireNow;
    strobes.sampleEn = holdIdle;
  end

endmodule

// File: rtl/press_pulse_top.sv
module press_pulse_top
  import press_pulse_pkg::*;
#(
  parameter bit LOCKOUT_MODE = 1'b0,
  parameter int HOLD_CYCLES  = 16,
  parameter int HIST_LEN     = 16,
  parameter int LOW_LEN      = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btnRaw,
  output logic pressPulse
);

  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  ppStrobe_t           strobes;
  logic [HIST_LEN-1:0] histQ;
  logic                histMatch;
  logic                riseSeen;
  logic [CNT_W-1:0]    holdCnt;

  press_pulse_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .HIST_LEN   (HIST_LEN),
    .LOW_LEN    (LOW_LEN)
  ) uDp (
    .clk      (clk),
    .rst      (rst),
    .btnRaw   (btnRaw),
    .strobes  (strobes),
    .histQ    (histQ),
    .histMatch(histMatch),
    .riseSeen (riseSeen),
    .pulseOut (pressPulse)
  );

  press_pulse_ctrl #(
    .LOCKOUT_MODE(LOCKOUT_MODE),
    .HOLD_CYCLES (HOLD_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .histMatch(histMatch),
    .riseSeen (riseSeen),
    .strobes  (strobes),
    .holdCnt  (holdCnt)
  );

endmodule

// File: rtl/press_pulse_chk.sv
module press_pulse_chk
  import press_pulse_pkg::*;
#(
  parameter bit LOCKOUT_MODE = 1'b0,
  parameter int HOLD_CYCLES  = 16,
  parameter int HIST_LEN     = 16,
  parameter int LOW_LEN      = 2,
  localparam int CNT_W       = $clog2(HOLD_CYCLES + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                pressPulse,
  input logic [HIST_LEN-1:0] histQ,
  input logic [CNT_W-1:0]    holdCnt
);

  localparam logic [63:0] PAT_WIDE = risePattern(HIST_LEN, LOW_LEN);
  localparam logic [HIST_LEN-1:0] PATTERN = PAT_WIDE[HIST_LEN-1:0];
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !pressPulse);

  assert_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    pressPulse |=> !pressPulse);

  assert_pattern_seen_R5: assert property (@(posedge clk) disable iff (rst)
    (!LOCKOUT_MODE && pressPulse) |-> ($past(histQ) == PATTERN));

  assert_hold_loaded_R8: assert property (@(posedge clk) disable iff (rst)
    (LOCKOUT_MODE && pressPulse) |-> (holdCnt == HOLD_LOAD));

  assert_hold_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (LOCKOUT_MODE && $past(holdCnt) != '0) |-> !pressPulse);

  assert_hold_drains_R9: assert property (@(posedge clk) disable iff (rst)
    (holdCnt != '0) |=> (holdCnt == $past(holdCnt) - 1'b1));

endmodule

bind press_pulse_top press_pulse_chk #(
  .LOCKOUT_MODE(LOCKOUT_MODE),
  .HOLD_CYCLES (HOLD_CYCLES),
  .HIST_LEN    (HIST_LEN),
  .LOW_LEN     (LOW_LEN)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .pressPulse(pressPulse),
  .histQ     (histQ),
  .holdCnt   (holdCnt)
);

// File: tb/tb_press_pulse_top.sv
module tb_press_pulse_top;

  localparam int HOLD = 16;
  localparam int MAXE = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn = 1'b0;
  logic patPulse, lockPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  bit btnAt  [MAXE];
  bit patAt  [MAXE];
  bit lockAt [MAXE];
  bit expLock[MAXE];
  int nE;
  int patCnt, lockCnt, patFirst, lockFirst;

  always #5 clk = ~clk;

  press_pulse_top #(.LOCKOUT_MODE(1'b0), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rst(rst), .btnRaw(btn), .pressPulse(patPulse));

  press_pulse_top #(.LOCKOUT_MODE(1'b1), .HOLD_CYCLES(HOLD)) dutLock (
    .clk(clk), .rst(rst), .btnRaw(btn), .pressPulse(lockPulse));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive a level before the next edge, observe outputs at the following falling edge.
  task automatic tick(input bit b);
    btn = b;
    @(posedge clk);
    @(negedge clk);
    if (nE < MAXE - 1) nE++;
    btnAt[nE]  = b;
    patAt[nE]  = patPulse;
    lockAt[nE] = lockPulse;
  endtask

  task automatic level(input bit b, input int n);
    for (int i = 0; i < n; i++) tick(b);
  endtask

  function automatic bit bAt(input int e);
    return (e >= 1 && e <= nE) ? btnAt[e] : 1'b0;
  endfunction

  // Recognition mode: pulse after edge p needs lows at p-18,p-17 and highs p-16..p-3.
  function automatic bit expPat(input int p);
    bit ok;
    ok = !bAt(p - 18) && !bAt(p - 17);
    for (int i = 3; i <= 16; i++) ok = ok && bAt(p - i);
    return ok;
  endfunction

  // Lockout mode: rise of the twice-delayed level fires, then HOLD edges are blind.
  function automatic void buildLock();
    int  left;
    bit  prev;
    left = 0;
    prev = 1'b0;
    for (int e = 1; e <= nE; e++) begin
      if (left > 0) begin
        left--;
        expLock[e] = 1'b0;
      end else begin
        bit s;
        s = bAt(e - 2);
        expLock[e] = s & ~prev;
        prev = s;
        if (expLock[e]) left = HOLD;
      end
    end
  endfunction

  task automatic startRun();
    nE = 0;
  endtask

  task automatic compareRun(input string reqP, input string reqL);
    int badP, badL;
    badP = -1; badL = -1;
    patCnt = 0; lockCnt = 0; patFirst = -1; lockFirst = -1;
    buildLock();
    for (int e = 1; e <= nE; e++) begin
      if (patAt[e])  begin patCnt++;  if (patFirst < 0)  patFirst = e;  end
      if (lockAt[e]) begin lockCnt++; if (lockFirst < 0) lockFirst = e; end
      if (badP < 0 && patAt[e] != expPat(e))      badP = e;
      if (badL < 0 && lockAt[e] != expLock[e])    badL = e;
    end
    check(badP < 0, reqP, "recognition pulse trace, first bad edge",
          badP < 0 ? 0 : int'(patAt[badP]), badP < 0 ? 0 : int'(expPat(badP)));
    check(badL < 0, reqL, "lockout pulse trace, first bad edge",
          badL < 0 ? 0 : int'(lockAt[badL]), badL < 0 ? 0 : int'(expLock[badL]));
  endtask

  initial begin : watchdog
    #(200000 * 10);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : stim
    bit quietInReset;
    void'($urandom(32'd20240611));

    // R1: reset holds the pulse low even with the button pressed.
    btn = 1'b1;
    quietInReset = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (patPulse || lockPulse) quietInReset = 1'b0;
    end
    check(quietInReset, "R1", "pulse during reset", 1, 0);
    btn = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(!patPulse && !lockPulse, "R1", "pulse after reset release",
          int'(patPulse | lockPulse), 0);
    startRun();
    level(1'b0, 30);

    // R3/R7/R2: clean press, exact latencies; R9: still high after hold-off.
    startRun();
    level(1'b0, 20); level(1'b1, 40); level(1'b0, 30);
    compareRun("R3", "R7");
    check(patFirst == 21 + 16, "R3", "recognition pulse edge", patFirst, 37);
    check(lockFirst == 21 + 2, "R2", "lockout pulse edge (two sync stages)", lockFirst, 23);
    check(patCnt == 1, "R4", "recognition pulse count", patCnt, 1);
    check(lockCnt == 1, "R9", "lockout count with level held past hold-off", lockCnt, 1);

    // R5: 14-sample high run fires, 13-sample run does not.
    startRun();
    level(1'b0, 20); level(1'b1, 14); level(1'b0, 20); level(1'b1, 13); level(1'b0, 20);
    compareRun("R5", "R8");
    check(patCnt == 1, "R5", "pulses for runs of 14 and 13", patCnt, 1);
    check(patFirst == 21 + 16, "R5", "edge of the 14-run pulse", patFirst, 37);

    // R8: single-cycle glitch accepted by lockout only.
    startRun();
    level(1'b0, 20); level(1'b1, 1); level(1'b0, 30);
    compareRun("R5", "R8");
    check(lockCnt == 1, "R8", "lockout pulses for a glitch", lockCnt, 1);
    check(patCnt == 0, "R5", "recognition pulses for a glitch", patCnt, 0);

    // R8: second rise inside the hold-off is ignored.
    startRun();
    level(1'b0, 20); level(1'b1, 3); level(1'b0, 3); level(1'b1, 3); level(1'b0, 30);
    compareRun("R5", "R8");
    check(lockCnt == 1, "R8", "lockout pulses, re-press inside hold-off", lockCnt, 1);

    // R9: second rise after the hold-off fires again.
    startRun();
    level(1'b0, 20); level(1'b1, 3); level(1'b0, 20); level(1'b1, 3); level(1'b0, 30);
    compareRun("R5", "R9");
    check(lockCnt == 2, "R9", "lockout pulses, re-press after hold-off", lockCnt, 2);
    check(lockFirst == 23, "R7", "first lockout pulse edge", lockFirst, 23);

    // R6: long hold, clean release.
    startRun();
    level(1'b0, 20); level(1'b1, 300); level(1'b0, 40);
    compareRun("R6", "R6");
    check(patCnt == 1, "R6", "recognition pulses for long hold", patCnt, 1);
    check(lockCnt == 1, "R6", "lockout pulses for long hold", lockCnt, 1);

    // R5/R6: random bounce bursts around a stable high level.
    for (int t = 0; t < 40; t++) begin
      int pressLen, holdLen, relLen, lastLow;
      pressLen = 3 + int'($urandom_range(9));
      holdLen  = 20 + int'($urandom_range(40));
      relLen   = int'($urandom_range(12));
      startRun();
      level(1'b0, 20);
      for (int i = 0; i < pressLen; i++) tick(1'($urandom_range(1)));
      level(1'b0, 2);
      lastLow = nE;
      level(1'b1, holdLen);
      for (int i = 0; i < relLen; i++) tick(1'($urandom_range(1)));
      level(1'b0, 25);
      compareRun("R5", "R8");
      check(patCnt == 1, "R6", "recognition pulses per bounced press", patCnt, 1);
      check(patFirst == lastLow + 17, "R3", "recognition pulse edge after bounce",
            patFirst, lastLow + 17);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule